// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block sits on the processor side of an interrupt path. It accepts a pending request of a given priority and turns it into an acknowledge bus cycle. It then works out the vector address that the handler fetch must read.

A request is taken only on an instruction-boundary strobe, and only when no higher-priority exception work is in progress. The sequencer first spends one cycle asking for processor state to be stacked and clearing the program bank extension field. It then runs an acknowledge cycle in CPU space. During that cycle the acknowledged priority sits in a fixed address pattern, and the same priority is written back into the interrupt mask field.

The cycle can end in three ways. The responder may put a vector number on the data bus. It may ask for an autovector. Or a bus error may arrive, either from outside or from the built-in bus monitor when nobody answers in time. Completion is marked by a single done pulse, together with the vector address (the vector number times two).

Top module: `irq_ack_sequencer`

## Requirements
- R1: A request starts only when, in the same cycle, `boundary_i` is high, `req_pend_i` is high and `exc_busy_i` is low, with the sequencer idle. A pending request without a strobe, or with `exc_busy_i` high, produces no `stack_req_o` pulse.
- R2: In the cycle after a request is accepted, `stack_req_o` and `bank_clr_o` are high for exactly one cycle. The acknowledge cycle starts in the cycle after that.
- R3: While `cycle_act_o` is high, `fc_o` is 3'b111 (CPU space). While the sequencer is idle, `fc_o` is 3'b000 and `addr_o` is zero.
- R4: During the acknowledge cycle, `addr_o[23:4]` are all ones, `addr_o[3:1]` hold the acknowledged priority and `addr_o[0]` is 1. The priority is the value of `req_lvl_i` captured when the request was accepted; later changes to `req_lvl_i` have no effect.
- R5: In the first acknowledge cycle, `mask_we_o` pulses for one cycle, and `mask_o` equals `addr_o[3:1]`.
- R6: When `dsack_i` is the only response, the vector number is the byte on `data_i`.
- R7: When `avec_i` is the strongest response, the vector number is 24 plus the acknowledged priority.
- R8: When `berr_i` is asserted, the vector number is the spurious number 24.
- R9: When responses arrive in the same cycle, bus error wins over autovector, and autovector wins over data acknowledge.
- R10: With no response, the internal monitor ends the cycle after TIMEOUT acknowledge cycles (default 16) with the spurious number 24.
- R11: `done_o` is a one-cycle pulse in the cycle after the response is sampled. `vec_addr_o` then equals the vector number shifted left by one, and holds until the next completion.
- R12: After completion the sequencer returns to idle. A request that is still pending does not restart it until the next boundary strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pend_i | input | 1 | An interrupt request is pending |
| req_lvl_i | input | 3 | Priority of the pending request |
| boundary_i | input | 1 | Instruction-boundary strobe |
| exc_busy_i | input | 1 | Higher-priority exception processing in progress |
| dsack_i | input | 1 | Data strobe acknowledge from the responder |
| avec_i | input | 1 | Autovector request |
| berr_i | input | 1 | External bus error |
| data_i | input | 8 | Vector number from the responder |
| fc_o | output | 3 | Function code |
| addr_o | output | 24 | Acknowledge cycle address |
| cycle_act_o | output | 1 | Acknowledge cycle in progress |
| stack_req_o | output | 1 | Request to stack processor state |
| bank_clr_o | output | 1 | Clear the program bank extension field |
| mask_we_o | output | 1 | Write strobe for the interrupt mask field |
| mask_o | output | 3 | New interrupt mask value |
| done_o | output | 1 | Sequence complete (one cycle) |
| vec_addr_o | output | 16 | Vector address |

## Verification
The hardest case to reach is the monitor timeout, because it needs a long stretch of silence on all three response inputs while the cycle is open. The bench holds every response low and counts acknowledge cycles. It checks that `cycle_act_o` is still high one cycle before the limit and that the spurious vector appears right after it. Same-cycle response collisions are reached by raising several response inputs in the same cycle. Changes to the priority input in the middle of a cycle are driven on purpose, to show that the captured level is the one that is used.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_STACK = 2'd1,
      ST_ACK   = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      RSP_NONE = 2'd0,
      RSP_DATA = 2'd1,
      RSP_AUTO = 2'd2,
      RSP_SPUR = 2'd3
   } rsp_kind_e;

   localparam logic [2:0] FC_CPU_SPACE = 3'b111;
   localparam logic [2:0] FC_IDLE      = 3'b000;

endpackage

// File: rtl/irq_ack_busmon.sv
module irq_ack_busmon #(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   output logic expire_o
);

   generate
      if (TIMEOUT == 0) begin : g_off
         assign expire_o = 1'b0;
      end else begin : g_on
         localparam int CNT_W = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!active_i) begin
               cnt_q <= '0;
            end else if (cnt_q != LAST) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign expire_o = active_i && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/irq_ack_vecres.sv
module irq_ack_vecres
   import irq_ack_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int LVL_W    = 3,
   parameter int SPUR_VEC = 24
) (
   input  logic              berr_i,
   input  logic              avec_i,
   input  logic              dsack_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [LVL_W-1:0]  lvl_i,
   output rsp_kind_e         kind_o,
   output logic [DATA_W-1:0] vec_o
);

   localparam logic [DATA_W-1:0] SPUR = DATA_W'(SPUR_VEC);

   always_comb begin
      kind_o = RSP_NONE;
      vec_o  = '0;
      if (berr_i) begin
         kind_o = RSP_SPUR;
         vec_o  = SPUR;
      end else if (avec_i) begin
         kind_o = RSP_AUTO;
         vec_o  = SPUR + DATA_W'(lvl_i);
      end else if (dsack_i) begin
         kind_o = RSP_DATA;
         vec_o  = data_i;
      end
   end

endmodule

// File: rtl/irq_ack_addrgen.sv
module irq_ack_addrgen
   import irq_ack_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int LVL_W  = 3
) (
   input  logic              active_i,
   input  logic [LVL_W-1:0]  lvl_i,
   output logic [2:0]        fc_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int ONES_W = ADDR_W - LVL_W - 1;

   always_comb begin
      if (active_i) begin
         fc_o   = FC_CPU_SPACE;
         addr_o = {{ONES_W{1'b1}}, lvl_i, 1'b1};
      end else begin
         fc_o   = FC_IDLE;
         addr_o = '0;
      end
   end

endmodule

// File: rtl/irq_ack_sequencer.sv
module irq_ack_sequencer
   import irq_ack_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 8,
   parameter int LVL_W    = 3,
   parameter int VADDR_W  = 16,
   parameter int TIMEOUT  = 16,
   parameter int SPUR_VEC = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_pend_i,
   input  logic [LVL_W-1:0]   req_lvl_i,
   input  logic               boundary_i,
   input  logic               exc_busy_i,
   input  logic               dsack_i,
   input  logic               avec_i,
   input  logic               berr_i,
   input  logic [DATA_W-1:0]  data_i,
   output logic [2:0]         fc_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               cycle_act_o,
   output logic               stack_req_o,
   output logic               bank_clr_o,
   output logic               mask_we_o,
   output logic [LVL_W-1:0]   mask_o,
   output logic               done_o,
   output logic [VADDR_W-1:0] vec_addr_o
);

   localparam int MAX_VEC = SPUR_VEC + (1 << LVL_W) - 1;

   generate
      if (ADDR_W < LVL_W + 2) begin : g_bad_addr
         $error("ADDR_W too narrow for the acknowledge pattern");
      end
      if (VADDR_W < DATA_W + 1) begin : g_bad_vaddr
         $error("VADDR_W must hold a shifted vector number");
      end
      if (MAX_VEC >= (1 << DATA_W)) begin : g_bad_vec
         $error("autovector range exceeds DATA_W");
      end
      if (TIMEOUT < 0) begin : g_bad_to
         $error("TIMEOUT must not be negative");
      end
   endgenerate

   seq_state_e        state_q, state_d;
   logic [LVL_W-1:0]  lvl_q;
   logic              first_q;
   logic [VADDR_W-1:0] vaddr_q;
   logic              expire;
   logic              in_ack;
   logic              accept;
   rsp_kind_e         kind;
   logic [DATA_W-1:0] vec_num;

   assign in_ack = (state_q == ST_ACK);
   assign accept = (state_q == ST_IDLE) && boundary_i && req_pend_i && !exc_busy_i;

   irq_ack_busmon #(
      .TIMEOUT (TIMEOUT)
   ) u_busmon (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (in_ack),
      .expire_o (expire)
   );

   irq_ack_vecres #(
      .DATA_W   (DATA_W),
      .LVL_W    (LVL_W),
      .SPUR_VEC (SPUR_VEC)
   ) u_vecres (
      .berr_i  (berr_i || expire),
      .avec_i  (avec_i),
      .dsack_i (dsack_i),
      .data_i  (data_i),
      .lvl_i   (lvl_q),
      .kind_o  (kind),
      .vec_o   (vec_num)
   );

   irq_ack_addrgen #(
      .ADDR_W (ADDR_W),
      .LVL_W  (LVL_W)
   ) u_addrgen (
      .active_i (in_ack),
      .lvl_i    (lvl_q),
      .fc_o     (fc_o),
      .addr_o   (addr_o)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = ST_STACK;
         ST_STACK: state_d = ST_ACK;
         ST_ACK:   if (kind != RSP_NONE) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lvl_q   <= '0;
         first_q <= 1'b0;
         vaddr_q <= '0;
      end else begin
         state_q <= state_d;
         first_q <= (state_q == ST_STACK);
         if (accept) begin
            lvl_q <= req_lvl_i;
         end
         if (in_ack && (kind != RSP_NONE)) begin
            vaddr_q <= VADDR_W'({vec_num, 1'b0});
         end
      end
   end

   assign cycle_act_o = in_ack;
   assign stack_req_o = (state_q == ST_STACK);
   assign bank_clr_o  = (state_q == ST_STACK);
   assign mask_we_o   = in_ack && first_q;
   assign mask_o      = addr_o[LVL_W:1];
   assign done_o      = (state_q == ST_DONE);
   assign vec_addr_o  = vaddr_q;

endmodule

// File: rtl/irq_ack_sequencer_chk.sv
module irq_ack_sequencer_chk #(
   parameter int ADDR_W  = 24,
   parameter int LVL_W   = 3,
   parameter int TIMEOUT = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_pend_i,
   input logic              boundary_i,
   input logic              exc_busy_i,
   input logic [2:0]        fc_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              cycle_act_o,
   input logic              stack_req_o,
   input logic              bank_clr_o,
   input logic              mask_we_o,
   input logic [LVL_W-1:0]  mask_o,
   input logic              done_o
);

   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stack_req_o) |-> $past(boundary_i && req_pend_i && !exc_busy_i)); // R1

   AST_STACK_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cycle_act_o) |-> $past(stack_req_o && bank_clr_o)); // R2

   AST_STACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stack_req_o |=> !stack_req_o); // R2

   AST_CPU_SPACE_FC: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_act_o |-> fc_o == 3'b111); // R3

   AST_ACK_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_act_o |-> (&addr_o[ADDR_W-1:LVL_W+1]) && addr_o[0]); // R4

   AST_MASK_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_o |-> cycle_act_o && (mask_o == addr_o[LVL_W:1])); // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !cycle_act_o); // R11

   generate
      if (TIMEOUT > 0) begin : g_mon
         localparam int W = $clog2(TIMEOUT + 1) + 1;
         logic [W-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            run_q <= '0;
            else if (!cycle_act_o) run_q <= '0;
            else if (run_q <= W'(TIMEOUT)) run_q <= run_q + 1'b1;
         end
         AST_MONITOR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cycle_act_o |-> run_q < W'(TIMEOUT)); // R10
      end
   endgenerate

endmodule

bind irq_ack_sequencer irq_ack_sequencer_chk #(
   .ADDR_W  (ADDR_W),
   .LVL_W   (LVL_W),
   .TIMEOUT (TIMEOUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_pend_i  (req_pend_i),
   .boundary_i  (boundary_i),
   .exc_busy_i  (exc_busy_i),
   .fc_o        (fc_o),
   .addr_o      (addr_o),
   .cycle_act_o (cycle_act_o),
   .stack_req_o (stack_req_o),
   .bank_clr_o  (bank_clr_o),
   .mask_we_o   (mask_we_o),
   .mask_o      (mask_o),
   .done_o      (done_o)
);

// File: tb/tb_irq_ack_sequencer.sv
module tb_irq_ack_sequencer;

   localparam int TIMEOUT = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_pend_i = 1'b0;
   logic [2:0]  req_lvl_i = '0;
   logic        boundary_i = 1'b0;
   logic        exc_busy_i = 1'b0;
   logic        dsack_i = 1'b0;
   logic        avec_i = 1'b0;
   logic        berr_i = 1'b0;
   logic [7:0]  data_i = '0;
   logic [2:0]  fc_o;
   logic [23:0] addr_o;
   logic        cycle_act_o, stack_req_o, bank_clr_o, mask_we_o, done_o;
   logic [2:0]  mask_o;
   logic [15:0] vec_addr_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   irq_ack_sequencer #(.TIMEOUT(TIMEOUT)) dut (
      .clk(clk), .rst_n(rst_n), .req_pend_i(req_pend_i), .req_lvl_i(req_lvl_i),
      .boundary_i(boundary_i), .exc_busy_i(exc_busy_i), .dsack_i(dsack_i),
      .avec_i(avec_i), .berr_i(berr_i), .data_i(data_i), .fc_o(fc_o),
      .addr_o(addr_o), .cycle_act_o(cycle_act_o), .stack_req_o(stack_req_o),
      .bank_clr_o(bank_clr_o), .mask_we_o(mask_we_o), .mask_o(mask_o),
      .done_o(done_o), .vec_addr_o(vec_addr_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] ack_addr(input logic [2:0] lvl);
      return {20'hFFFFF, lvl, 1'b1};
   endfunction

   // Accept a request, check stacking and the first acknowledge cycle.
   // Returns at the negedge inside acknowledge cycle 0.
   task automatic open_cycle(input logic [2:0] lvl);
      @(negedge clk);
      req_pend_i = 1'b1; req_lvl_i = lvl; boundary_i = 1'b1;
      @(negedge clk);
      boundary_i = 1'b0;
      chk("R2 stack_req", stack_req_o, 1);
      chk("R2 bank_clr", bank_clr_o, 1);
      chk("R2 no ack yet", cycle_act_o, 0);
      @(negedge clk);
      chk("R2 stack one cycle", stack_req_o, 0);
      chk("R3 fc cpu space", fc_o, 3'b111);
      chk("R4 ack address", addr_o, ack_addr(lvl));
      chk("R5 mask_we", mask_we_o, 1);
      chk("R5 mask value", mask_o, lvl);
   endtask

   // Responses are already driven; check completion.
   task automatic close_cycle(input string req, input logic [15:0] exp_va);
      @(negedge clk);
      dsack_i = 0; avec_i = 0; berr_i = 0;
      chk({req, " done"}, done_o, 1);
      chk({req, " vec_addr"}, vec_addr_o, exp_va);
      chk("R11 ack ended", cycle_act_o, 0);
      @(negedge clk);
      chk("R11 done one cycle", done_o, 0);
      chk("R11 vec_addr held", vec_addr_o, exp_va);
      chk("R3 idle fc", fc_o, 3'b000);
      chk("R3 idle addr", addr_o, 0);
      req_pend_i = 0;
   endtask

   task automatic t_reset;
      chk("R3 reset fc", fc_o, 0);
      chk("R3 reset addr", addr_o, 0);
      chk("R11 reset done", done_o, 0);
      chk("R2 reset stack", stack_req_o, 0);
      chk("R11 reset vec", vec_addr_o, 0);
   endtask

   task automatic t_gating;
      @(negedge clk);
      req_pend_i = 1; req_lvl_i = 3'd4;
      repeat (3) begin
         @(negedge clk);
         chk("R1 no strobe", stack_req_o, 0);
      end
      exc_busy_i = 1; boundary_i = 1;
      @(negedge clk);
      boundary_i = 0; exc_busy_i = 0;
      chk("R1 busy blocks", stack_req_o, 0);
      @(negedge clk);
      chk("R1 busy blocks ack", cycle_act_o, 0);
      req_pend_i = 0; boundary_i = 1;
      @(negedge clk);
      boundary_i = 0;
      chk("R1 no pend", stack_req_o, 0);
   endtask

   task automatic t_data;
      open_cycle(3'd3);
      dsack_i = 1; data_i = 8'hC4;
      close_cycle("R6", 16'h0188);
   endtask

   task automatic t_data_wait;
      open_cycle(3'd1);
      repeat (3) @(negedge clk);
      chk("R6 waiting", cycle_act_o, 1);
      dsack_i = 1; data_i = 8'h40;
      close_cycle("R6 late", 16'h0080);
   endtask

   task automatic t_auto;
      open_cycle(3'd5);
      req_lvl_i = 3'd2;
      @(negedge clk);
      chk("R4 level latched", addr_o, ack_addr(3'd5));
      avec_i = 1;
      close_cycle("R7", 16'(29 * 2));
   endtask

   task automatic t_berr;
      open_cycle(3'd7);
      berr_i = 1;
      close_cycle("R8", 16'(24 * 2));
   endtask

   task automatic t_priority;
      open_cycle(3'd6);
      berr_i = 1; avec_i = 1; dsack_i = 1; data_i = 8'h99;
      close_cycle("R9 berr wins", 16'(24 * 2));
      open_cycle(3'd6);
      avec_i = 1; dsack_i = 1; data_i = 8'h99;
      close_cycle("R9 avec wins", 16'(30 * 2));
   endtask

   task automatic t_timeout;
      open_cycle(3'd2);
      repeat (TIMEOUT - 1) @(negedge clk);
      chk("R10 still waiting", cycle_act_o, 1);
      chk("R10 no early done", done_o, 0);
      close_cycle("R10", 16'(24 * 2));
   endtask

   task automatic t_no_restart;
      open_cycle(3'd4);
      dsack_i = 1; data_i = 8'h21;
      @(negedge clk);
      dsack_i = 0;
      chk("R11 done", done_o, 1);
      repeat (3) begin
         @(negedge clk);
         chk("R12 no restart", stack_req_o | cycle_act_o, 0);
      end
      boundary_i = 1;
      @(negedge clk);
      boundary_i = 0;
      chk("R12 restart on strobe", stack_req_o, 1);
      @(negedge clk);
      avec_i = 1;
      close_cycle("R12 second", 16'(28 * 2));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_gating();
      t_data();
      t_data_wait();
      t_auto();
      t_berr();
      t_priority();
      t_timeout();
      t_no_restart();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule